// File: doc/BRIEF.md
# Character Dot Address Sequencer

This block walks through the stored dot-position bytes of one character at a time for a dot-drawn readout display. An external character counter supplies a character code, which selects a 16-byte block in a character ROM, together with the column and row where that character sits. Each pulse of the dot-request strobe displays one dot. The sequencer forms the ROM address for the current dot. It splits the byte read back into a horizontal and a vertical position word and registers both. It then moves on to the next byte.

A character ends when a byte has its end flag (bit 7) low. That dot is still shown. On the strobe that follows, the sequencer raises a character-advance request, clears its dot counter and shows nothing, because that strobe slot is spent on the change of character. A character whose first byte is already marked final, such as a space, therefore uses exactly two strobes. A character longer than 16 dots spills into the following 16-byte block: a fifth counter bit is ORed into the lowest code bit of the address. Such characters must use an even code. If 32 dots pass with no end flag, the sequencer forces the end of the character and sets a sticky error flag.

Top module: `chardot_sequencer`

## Requirements
- R1: While `rstN` is low at a clock edge, the dot counter and the delayed end flag clear, `hWord`, `vWord` and `errFlag` go to zero, and `charAdvance` stays low even if `dotReq` is high.
- R2: `romAddr` is {charCode[5:1], charCode[0] OR count[4], count[3:0]}, where count is the 5-bit dot counter.
- R3: On a strobe that displays a dot whose byte has bit 7 high, the count goes up by one unless it is 31. On a strobe that displays a byte with bit 7 low, the count holds.
- R4: The strobe after the one that displayed a final dot is a transition strobe. On it, `charAdvance` is high during that cycle, the count returns to zero and the position words keep their value. `charAdvance` is low on every other cycle.
- R5: For a character whose first byte has bit 7 low (a space), `charAdvance` comes on the second strobe after the character is selected.
- R6: With an even code, dots 16 to 31 of a long character address the next 16-byte block (address bit 4 set).
- R7: On every strobe that displays a dot, `hWord` is loaded with {charCol, byte[2:0]}.
- R8: On every strobe that displays a dot, `vWord` is loaded with {charRow, byte[6:3]}.
- R9: If the strobe that displays count 31 sees bit 7 high, that dot is treated as final and `errFlag` is set. `errFlag` then stays high until reset.
- R10: In a cycle with `dotReq` low, the count, `hWord`, `vWord` and `errFlag` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| dotReq | input | 1 | One-cycle strobe requesting the next dot |
| charCode | input | 6 | Character code (ROM block select) |
| charCol | input | 5 | Column of the current character |
| charRow | input | 2 | Display row of the current character |
| romData | input | 8 | Byte read from the character ROM at `romAddr` |
| romAddr | output | 10 | Character ROM dot address |
| charAdvance | output | 1 | Request to step to the next character |
| hWord | output | 8 | Registered horizontal dot position |
| vWord | output | 6 | Registered vertical dot position |
| errFlag | output | 1 | Sticky flag: character ran past 32 dots |

## Verification
The hardest state to reach from the ports is the forced end at count 31. It needs a character block pair whose 32 bytes all have bit 7 high. The bench ROM model gives one even code exactly that content, so the counter runs through both blocks and takes the overrun path. A reset issued partway through a long character then shows that the sticky flag and the high counter bit both clear. Random gaps between strobes are mixed with space characters and with characters that end exactly on dot 16 and on dot 32. A reference model compares against these cases on every clock.

// File: rtl/chardot_pkg.sv
package chardot_pkg;
  localparam int BLOCK_W = 4;
  localparam int CNT_W   = BLOCK_W + 1;
  localparam int DATA_W  = 8;
  localparam int EOC_BIT = DATA_W - 1;
  localparam int HDOT_W  = 3;
  localparam int VDOT_W  = EOC_BIT - HDOT_W;

  typedef struct packed {
    logic load;    // latch position words for the addressed dot
    logic inc;     // step to the next dot byte
    logic clear;   // return counter to dot zero
    logic setEnd;  // remember that the displayed dot was final
    logic clrEnd;  // forget the remembered end
    logic setErr;  // overrun seen
  } seqCtl_t;
endpackage

// File: rtl/chardot_ctrl.sv
module chardot_ctrl
  import chardot_pkg::*;
#(
  parameter int CNT_WIDTH = CNT_W
) (
  input  logic                 rstN,
  input  logic                 dotReq,
  input  logic                 endFlagN,
  input  logic                 endDly,
  input  logic [CNT_WIDTH-1:0] dotCnt,
  output seqCtl_t              ctl,
  output logic                 advance
);
  localparam logic [CNT_WIDTH-1:0] CntLast = '1;

  logic countFull;
  assign countFull = (dotCnt == CntLast);

  always_comb begin
    ctl     = '0;
    advance = 1'b0;
    if (rstN && dotReq) begin
      if (endDly) begin
        ctl.clear  = 1'b1;
        ctl.clrEnd = 1'b1;
        advance    = 1'b1;
      end else begin
        ctl.load = 1'b1;
        if (!endFlagN) begin
          ctl.setEnd = 1'b1;
        end else if (countFull) begin
          ctl.setEnd = 1'b1;
          ctl.setErr = 1'b1;
        end else begin
          ctl.inc = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chardot_dpath.sv
module chardot_dpath
  import chardot_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqCtl_t                    ctl,
  input  logic [CODE_W-1:0]          charCode,
  input  logic [COL_W-1:0]           charCol,
  input  logic [ROW_W-1:0]           charRow,
  input  logic [EOC_BIT-1:0]         dotBits,
  output logic [CODE_W+BLOCK_W-1:0]  romAddr,
  output logic [CNT_W-1:0]           dotCnt,
  output logic                       endDly,
  output logic [COL_W+HDOT_W-1:0]    hWord,
  output logic [ROW_W+VDOT_W-1:0]    vWord,
  output logic                       errFlag
);
  logic blockSel;
  assign blockSel = charCode[0] | dotCnt[CNT_W-1];

  generate
    if (CODE_W > 1) begin : g_wide_code
      assign romAddr = {charCode[CODE_W-1:1], blockSel, dotCnt[BLOCK_W-1:0]};
    end else begin : g_narrow_code
      assign romAddr = {blockSel, dotCnt[BLOCK_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotCnt  <= '0;
      endDly  <= 1'b0;
      errFlag <= 1'b0;
      hWord   <= '0;
      vWord   <= '0;
    end else begin
      if (ctl.clear)     dotCnt <= '0;
      else if (ctl.inc)  dotCnt <= dotCnt + 1'b1;

      if (ctl.setEnd)      endDly <= 1'b1;
      else if (ctl.clrEnd) endDly <= 1'b0;

      if (ctl.setErr) errFlag <= 1'b1;

      if (ctl.load) begin
        hWord <= {charCol, dotBits[HDOT_W-1:0]};
        vWord <= {charRow, dotBits[EOC_BIT-1:HDOT_W]};
      end
    end
  end
endmodule

// File: rtl/chardot_sequencer.sv
module chardot_sequencer
  import chardot_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int COL_W  = 5,
  parameter int ROW_W  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dotReq,
  input  logic [CODE_W-1:0]         charCode,
  input  logic [COL_W-1:0]          charCol,
  input  logic [ROW_W-1:0]          charRow,
  input  logic [DATA_W-1:0]         romData,
  output logic [CODE_W+BLOCK_W-1:0] romAddr,
  output logic                      charAdvance,
  output logic [COL_W+HDOT_W-1:0]   hWord,
  output logic [ROW_W+VDOT_W-1:0]   vWord,
  output logic                      errFlag
);
  seqCtl_t          ctl;
  logic [CNT_W-1:0] dotCnt;
  logic             endDly;

  chardot_ctrl #(.CNT_WIDTH(CNT_W)) u_ctrl (
    .rstN     (rstN),
    .dotReq   (dotReq),
    .endFlagN (romData[EOC_BIT]),
    .endDly   (endDly),
    .dotCnt   (dotCnt),
    .ctl      (ctl),
    .advance  (charAdvance)
  );

  chardot_dpath #(.CODE_W(CODE_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .charCode (charCode),
    .charCol  (charCol),
    .charRow  (charRow),
    .dotBits  (romData[EOC_BIT-1:0]),
    .romAddr  (romAddr),
    .dotCnt   (dotCnt),
    .endDly   (endDly),
    .hWord    (hWord),
    .vWord    (vWord),
    .errFlag  (errFlag)
  );
endmodule

// File: rtl/chardot_sequencer_checker.sv
module chardot_sequencer_checker
  import chardot_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             dotReq,
  input logic             romFlagN,
  input logic             charAdvance,
  input logic [CNT_W-1:0] dotCnt,
  input logic [7:0]       hWord,
  input logic [5:0]       vWord,
  input logic             errFlag
);
  localparam logic [CNT_W-1:0] CntLast = '1;

  p_adv_on_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    charAdvance |-> dotReq);

  p_adv_zeroes_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    charAdvance |=> (dotCnt == '0));

  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dotReq && !charAdvance && romFlagN && dotCnt != CntLast)
      |=> (dotCnt == CNT_W'($past(dotCnt) + 1'b1)));

  p_final_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dotReq && !charAdvance && !romFlagN) |=> $stable(dotCnt));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dotReq |=> ($stable(dotCnt) && $stable(hWord) && $stable(vWord) && $stable(errFlag)));
endmodule

bind chardot_sequencer chardot_sequencer_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .dotReq      (dotReq),
  .romFlagN    (romData[7]),
  .charAdvance (charAdvance),
  .dotCnt      (dotCnt),
  .hWord       (hWord),
  .vWord       (vWord),
  .errFlag     (errFlag)
);

// File: tb/chardot_sequencer_bench.sv
module chardot_sequencer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dotReq = 1'b0;
  logic [5:0] charCode = '0;
  logic [4:0] charCol = '0;
  logic [1:0] charRow = '0;
  logic [7:0] romData;
  logic [9:0] romAddr;
  logic       charAdvance;
  logic [7:0] hWord;
  logic [5:0] vWord;
  logic       errFlag;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int  mCnt = 0;
  bit  mEnd = 0;
  bit  mErr = 0;
  int  mH = 0;
  int  mV = 0;
  bit  advancedFlag = 0;

  always #10 clk = ~clk;

  chardot_sequencer u_chardot_sequencer (
    .clk(clk), .rstN(rstN), .dotReq(dotReq), .charCode(charCode),
    .charCol(charCol), .charRow(charRow), .romData(romData),
    .romAddr(romAddr), .charAdvance(charAdvance), .hWord(hWord),
    .vWord(vWord), .errFlag(errFlag)
  );

  // ROM content: codes 2, 4, 6 are long (two blocks); 6 has no end flag.
  function automatic bit isLong(int c);
    return (c == 2) || (c == 4) || (c == 6);
  endfunction

  function automatic int charLen(int c);
    if (c == 0) return 1;
    if (c == 2) return 20;
    if (c == 4) return 32;
    if (c == 6) return 0;
    return (c % 16) + 1;
  endfunction

  function automatic logic [7:0] romByte(int a);
    int blk = a >> 4;
    int idx = a & 15;
    int own;
    int d;
    if ((blk % 2 == 1) && isLong(blk - 1)) begin
      own = blk - 1; d = 16 + idx;
    end else begin
      own = blk; d = idx;
    end
    romByte[6:0] = 7'((a * 29 + 11) & 127);
    romByte[7]   = (d == charLen(own) - 1) ? 1'b0 : 1'b1;
  endfunction

  assign romData = romByte(int'(romAddr));

  function automatic int modelAddr();
    return ((int'(charCode) >> 1) << 5) | (((int'(charCode) & 1) | (mCnt >> 4)) << 4) | (mCnt & 15);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mEnd = 0; mErr = 0; mH = 0; mV = 0;
    end else if (dotReq) begin
      if (mEnd) begin
        mCnt = 0; mEnd = 0; advancedFlag = 1;
      end else begin
        logic [7:0] b;
        b = romByte(modelAddr());
        mH = (int'(charCol) << 3) | int'(b[2:0]);
        mV = (int'(charRow) << 4) | int'(b[6:3]);
        if (!b[7]) mEnd = 1;
        else if (mCnt == 31) begin mEnd = 1; mErr = 1; end
        else mCnt = mCnt + 1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(bit inReset);
    int expAdv = (rstN && dotReq && mEnd) ? 1 : 0;
    check(inReset ? "R1" : (mCnt >= 16 ? "R6" : "R2"), "romAddr", int'(romAddr), modelAddr());
    check(inReset ? "R1" : (charCode == 0 ? "R5" : "R4"), "charAdvance", int'(charAdvance), expAdv);
    check(inReset ? "R1" : "R7", "hWord", int'(hWord), mH);
    check(inReset ? "R1" : "R8", "vWord", int'(vWord), mV);
    check(inReset ? "R1" : "R9", "errFlag", int'(errFlag), int'(mErr));
  endtask

  task automatic runSeq(int seqLen, int codes[16]);
    int idx = 0;
    charCode = 6'(codes[0]);
    while (idx < seqLen) begin
      @(negedge clk);
      if (advancedFlag) begin
        advancedFlag = 0;
        idx++;
        if (idx < seqLen) begin
          charCode = 6'(codes[idx]);
          charCol  = 5'($urandom);
          charRow  = 2'($urandom);
        end
      end
      dotReq = (idx < seqLen) && (($urandom % 4) != 0);
      #2 compareAll(0);
    end
    @(negedge clk);
    dotReq = 0;
    #2 compareAll(0);
  endtask

  initial begin
    int codes[16] = '{0, 1, 2, 5, 4, 0, 0, 9, 6, 13, 2, 15, 0, 4, 3, 1};
    logic [9:0] savedAddr;
    logic [7:0] savedH;

    // R1: reset with strobes active
    repeat (3) begin
      @(negedge clk);
      dotReq = 1;
      #2 compareAll(1);
    end
    @(negedge clk);
    rstN = 1; dotReq = 0;
    #2 compareAll(0);

    // R3, R4, R5, R6, R9: full character pass including overrun on code 6
    runSeq(16, codes);
    check("R9", "errFlag sticky after overrun", int'(errFlag), 1);

    // R10: idle stretch
    savedAddr = romAddr; savedH = hWord;
    repeat (8) begin
      @(negedge clk);
      dotReq = 0;
      #2 compareAll(0);
    end
    check("R10", "romAddr idle", int'(romAddr), int'(savedAddr));
    check("R10", "hWord idle", int'(hWord), int'(savedH));

    // partway into a long character, then reset (R1)
    charCode = 6'd4;
    advancedFlag = 0;
    repeat (20) begin
      @(negedge clk);
      dotReq = 1;
      #2 compareAll(0);
    end
    check("R6", "long char block bit", int'(romAddr[4]), 1);
    @(negedge clk);
    rstN = 0; dotReq = 1;
    #2 compareAll(1);
    @(negedge clk);
    rstN = 1; dotReq = 0;
    #2 compareAll(0);
    check("R1", "errFlag cleared", int'(errFlag), 0);
    check("R1", "count cleared", int'(romAddr[4:0]), 0);
    advancedFlag = 0;

    // second pass with new random gaps and positions
    runSeq(16, codes);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule